// File: doc/BRIEF.md
# PWM Output Steering and Fault Shutdown Stage

This block sits between a single PWM waveform and a bank of output pins. Each pin has three controls: a steering bit that decides whether the PWM reaches it, a polarity bit that chooses an active-high or active-low sense, and a driver-enable bit. When a pin is not steered, it rests at its inactive level. When its driver is off, it is released.

A fault controller watches three comparator fault lines and one external fault line. Each line has its own mask bit. When the controller is armed and an unmasked fault is present, it latches a shutdown. Software can also force a shutdown directly, with or without arming. While the shutdown holds, every pin is driven to its own programmed level. That level appears on the pin as written, whatever the polarity setting.

Recovery follows one of two policies:
- **Automatic:** the stage resumes at the first period event that finds no fault.
- **Software-cleared:** software must first clear the status flag, and that clear is refused while a fault persists. The outputs then return at the next period event.

Top module: `outSteerShutdown`

## Requirements
- R1: When a pin's steering bit is 1, its output follows the PWM input through its polarity. When the steering bit is 0, the pin sits at its inactive level, which equals its polarity bit.
- R2: A polarity bit of 0 gives an active-high pin (output = steered PWM). A polarity bit of 1 gives an active-low pin (output = inverted steered PWM).
- R3: Each driver-enable output `pinOe[i]` always equals `drvEn[i]`, in every state including shutdown.
- R4: While `sdEnable` is 0 and `swOverride` is 0, fault inputs have no effect: `sdStatus` stays 0 and the pins keep following R1 and R2.
- R5: Fault source bit order is bits 0..2 for `cmpFault[0..2]` and bit 3 for `extFault`. A source whose `faultMask` bit is 0 never trips the stage.
- R6: A trip is an unmasked active fault sampled at a clock edge while `sdEnable` is 1. From the next cycle, `sdStatus` reads 1 and every `pinOut[i]` equals `sdLevel[i]`, regardless of polarity.
- R7: `swOverride` high at a clock edge trips the stage as in R6, even when `sdEnable` is 0 and no fault is present. The stage cannot leave shutdown while `swOverride` stays high.
- R8: With `autoRestart` = 1, the stage stays shut down while any trip condition is present. It returns to normal output, with `sdStatus` = 0, after the first clock edge where `periodEvt` is 1 and no trip condition exists.
- R9: With `autoRestart` = 0:
  - `sdStatus` stays 1 until a `statusClr` pulse is sampled at an edge with no trip condition. A clear sampled while a trip condition is present is ignored.
  - Period events alone never end the shutdown.
  - After an accepted clear, `sdStatus` reads 0, but the pins keep their shutdown levels until the next edge with `periodEvt` = 1. A new trip before that edge returns the stage to shutdown.
- R10: While `rstN` is low, `sdStatus` is 0 and the pins follow R1 and R2, whatever the fault inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwmIn | input | 1 | PWM waveform to be distributed |
| periodEvt | input | 1 | One-cycle pulse at each PWM period boundary |
| steerEn | input | 6 | Per-pin steering enable |
| polInv | input | 6 | Per-pin polarity: 1 = active low |
| drvEn | input | 6 | Per-pin output driver enable |
| sdLevel | input | 6 | Per-pin level forced during shutdown |
| sdEnable | input | 1 | Arms the fault-triggered shutdown |
| autoRestart | input | 1 | 1 = automatic recovery, 0 = software clear required |
| swOverride | input | 1 | Forces shutdown from software |
| statusClr | input | 1 | Software clear strobe for the shutdown flag |
| faultMask | input | 4 | Per-source fault enable, bit 3 = external |
| cmpFault | input | 3 | Synchronized comparator fault lines |
| extFault | input | 1 | External fault line |
| pinOut | output | 6 | Pin output values |
| pinOe | output | 6 | Pin driver enables |
| sdStatus | output | 1 | Shutdown flag: 1 after a shutdown until recovery or clear |

## Verification
The bench targets the timing corners of recovery, each of which a wrong design would reveal:
- **Clear sampled during a live fault:** a design that accepts it would drop the flag too early.
- **Period event during shutdown in software-cleared mode:** a design that honours it would resume without permission.
- **The armed-but-not-yet-resumed window after an accepted clear:** a design that restores the outputs at the clear would resume mid-period, and one that ignores a fresh fault in this window would resume into a fault.
- **Override with the fault logic disarmed**, and **a masked external fault**, which a wrong design would either miss or honour.
- **Mixed polarity and shutdown levels:** a design that applies the shutdown level before the inversion would show the complement on active-low pins.

// File: rtl/outStagePkg.sv
package outStagePkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DOWN  = 2'd1,
    ST_ARMED = 2'd2
  } sdState_e;

  // strobes from the control side to the pin datapath
  typedef struct packed {
    logic forceLevel;
  } stageCtl_t;

endpackage

// File: rtl/outStageFaultGate.sv
module outStageFaultGate #(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] faultMask,
  input  logic               armed,
  output logic               faultHit
);

  logic [NUM_SRC-1:0] srcHit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = faultIn[s] & faultMask[s];
  end

  assign faultHit = armed & (|srcHit);

endmodule

// File: rtl/outStageCtrl.sv
module outStageCtrl
  import outStagePkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] faultMask,
  input  logic               sdEnable,
  input  logic               swOverride,
  input  logic               autoRestart,
  input  logic               statusClr,
  input  logic               periodEvt,
  output stageCtl_t          ctl,
  output logic               sdStatus
);

  logic     faultHit;
  logic     trip;
  sdState_e state, stateNxt;

  outStageFaultGate #(.NUM_SRC(NUM_SRC)) uGate (
    .faultIn  (faultIn),
    .faultMask(faultMask),
    .armed    (sdEnable),
    .faultHit (faultHit)
  );

  assign trip = faultHit | swOverride;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (trip) stateNxt = ST_DOWN;
      end
      ST_DOWN: begin
        if (!trip) begin
          if (autoRestart) begin
            if (periodEvt) stateNxt = ST_RUN;
          end else if (statusClr) begin
            stateNxt = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (trip)           stateNxt = ST_DOWN;
        else if (periodEvt) stateNxt = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign ctl.forceLevel = (state != ST_RUN);
  assign sdStatus       = (state == ST_DOWN);

  // R6 R7
  trip_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    trip |=> sdStatus);

  // R4
  disarmed_stays_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sdEnable && !swOverride && state == ST_RUN) |=> state == ST_RUN);

  // R8
  resume_needs_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && !periodEvt) |=> state != ST_RUN);

  // R9
  manual_status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && !autoRestart && !statusClr) |=> sdStatus);

  // R9
  clear_refused_in_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN && trip) |=> state == ST_DOWN);

endmodule

// File: rtl/outStagePin.sv
module outStagePin (
  input  logic pwm,
  input  logic steer,
  input  logic invert,
  input  logic drive,
  input  logic shutLevel,
  input  logic forceLevel,
  output logic pinVal,
  output logic pinEn
);

  logic steered;
  logic shaped;

  assign steered = pwm & steer;
  assign shaped  = steered ^ invert;
  assign pinVal  = forceLevel ? shutLevel : shaped;
  assign pinEn   = drive;

endmodule

// File: rtl/outStageData.sv
module outStageData
  import outStagePkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                pwmIn,
  input  logic [NUM_PINS-1:0] steerEn,
  input  logic [NUM_PINS-1:0] polInv,
  input  logic [NUM_PINS-1:0] drvEn,
  input  logic [NUM_PINS-1:0] sdLevel,
  input  stageCtl_t           ctl,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    outStagePin uPin (
      .pwm       (pwmIn),
      .steer     (steerEn[p]),
      .invert    (polInv[p]),
      .drive     (drvEn[p]),
      .shutLevel (sdLevel[p]),
      .forceLevel(ctl.forceLevel),
      .pinVal    (pinOut[p]),
      .pinEn     (pinOe[p])
    );
  end

endmodule

// File: rtl/outSteerShutdown.sv
module outSteerShutdown
  import outStagePkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int NUM_CMP  = 3,
  localparam int NUM_SRC = NUM_CMP + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwmIn,
  input  logic                periodEvt,
  input  logic [NUM_PINS-1:0] steerEn,
  input  logic [NUM_PINS-1:0] polInv,
  input  logic [NUM_PINS-1:0] drvEn,
  input  logic [NUM_PINS-1:0] sdLevel,
  input  logic                sdEnable,
  input  logic                autoRestart,
  input  logic                swOverride,
  input  logic                statusClr,
  input  logic [NUM_SRC-1:0]  faultMask,
  input  logic [NUM_CMP-1:0]  cmpFault,
  input  logic                extFault,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                sdStatus
);

  stageCtl_t          ctl;
  logic [NUM_SRC-1:0] faultVec;

  // external line occupies the top source position
  assign faultVec = {extFault, cmpFault};

  outStageCtrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultIn    (faultVec),
    .faultMask  (faultMask),
    .sdEnable   (sdEnable),
    .swOverride (swOverride),
    .autoRestart(autoRestart),
    .statusClr  (statusClr),
    .periodEvt  (periodEvt),
    .ctl        (ctl),
    .sdStatus   (sdStatus)
  );

  outStageData #(.NUM_PINS(NUM_PINS)) uData (
    .pwmIn  (pwmIn),
    .steerEn(steerEn),
    .polInv (polInv),
    .drvEn  (drvEn),
    .sdLevel(sdLevel),
    .ctl    (ctl),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  // R6
  status_forces_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdStatus |-> pinOut == sdLevel);

  // R3
  driver_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe == drvEn);

endmodule

// File: tb/tb_outSteerShutdown.sv
module tb_outSteerShutdown;

  localparam int NP = 6;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pwmIn = 1'b0, periodEvt = 1'b0;
  logic [NP-1:0] steerEn = '0, polInv = '0, drvEn = '0, sdLevel = '0;
  logic          sdEnable = 1'b0, autoRestart = 1'b0, swOverride = 1'b0, statusClr = 1'b0;
  logic [NC:0]   faultMask = '0;
  logic [NC-1:0] cmpFault = '0;
  logic          extFault = 1'b0;
  logic [NP-1:0] pinOut, pinOe;
  logic          sdStatus;

  int total = 0;
  int bad = 0;
  int mSt = 0; // 0 running, 1 shut down, 2 cleared and waiting for period

  always #4 clk = ~clk;

  outSteerShutdown dut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .periodEvt(periodEvt),
    .steerEn(steerEn), .polInv(polInv), .drvEn(drvEn), .sdLevel(sdLevel),
    .sdEnable(sdEnable), .autoRestart(autoRestart), .swOverride(swOverride),
    .statusClr(statusClr), .faultMask(faultMask), .cmpFault(cmpFault),
    .extFault(extFault), .pinOut(pinOut), .pinOe(pinOe), .sdStatus(sdStatus)
  );

  function automatic logic tripNow();
    logic [NC:0] src;
    src = {extFault, cmpFault} & faultMask;
    return (sdEnable && (|src)) || swOverride;
  endfunction

  function automatic logic [NP-1:0] expPins();
    if (mSt != 0) return sdLevel;
    return (steerEn & {NP{pwmIn}}) ^ polInv;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk((mSt != 0) ? "R6 pin level" : "R1 R2 pin value", 8'(pinOut), 8'(expPins()));
    chk("R3 driver enable", 8'(pinOe), 8'(drvEn));
    chk(autoRestart ? "R8 status" : "R9 status", 8'(sdStatus), 8'(mSt == 1));
  endtask

  task automatic tick();
    logic t;
    @(posedge clk);
    t = tripNow();
    if (!rstN) mSt = 0;
    else case (mSt)
      0: if (t) mSt = 1;
      1: if (!t) begin
           if (autoRestart) begin if (periodEvt) mSt = 0; end
           else if (statusClr) mSt = 2;
         end
      default: if (t) mSt = 1; else if (periodEvt) mSt = 0;
    endcase
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R10: faults present during reset have no effect
    sdEnable = 1; faultMask = '1; cmpFault = '1; steerEn = 6'b000101; polInv = 6'b000011;
    drvEn = 6'b110011; pwmIn = 1;
    repeat (3) tick();
    chk("R10 status in reset", 8'(sdStatus), 8'd0);
    chk("R10 pins in reset", 8'(pinOut), 8'(6'b000110));
    @(negedge clk); rstN = 1; cmpFault = '0; sdEnable = 0;

    // R1 R2: steering and polarity with toggling pwm
    for (int i = 0; i < 6; i++) begin pwmIn = i[0]; tick(); end
    pwmIn = 1; tick();
    chk("R1 R2 steered mix", 8'(pinOut), 8'(6'b000110));

    // R4: disarmed, all faults asserted
    sdEnable = 0; faultMask = '1; cmpFault = '1; extFault = 1; repeat (3) tick();
    chk("R4 disarmed status", 8'(sdStatus), 8'd0);
    cmpFault = '0; extFault = 0;

    // R5: masked external fault ignored, comparator 1 trips
    sdEnable = 1; faultMask = 4'b0111; extFault = 1; autoRestart = 1; repeat (2) tick();
    chk("R5 masked external", 8'(sdStatus), 8'd0);
    sdLevel = 6'b101001; cmpFault = 3'b010; tick();
    chk("R6 trip status", 8'(sdStatus), 8'd1);
    chk("R6 shutdown levels", 8'(pinOut), 8'(6'b101001));

    // R8: fault gone but no period -> stays; period -> resume
    cmpFault = '0; repeat (2) tick();
    chk("R8 wait for period", 8'(sdStatus), 8'd1);
    periodEvt = 1; tick(); periodEvt = 0;
    chk("R8 auto resume", 8'(sdStatus), 8'd0);
    extFault = 0;

    // R7: override with fault logic disarmed
    sdEnable = 0; swOverride = 1; tick();
    chk("R7 override trips", 8'(sdStatus), 8'd1);
    periodEvt = 1; tick(); periodEvt = 0;
    chk("R7 override holds", 8'(sdStatus), 8'd1);
    swOverride = 0; periodEvt = 1; tick(); periodEvt = 0;
    chk("R8 resume after override", 8'(sdStatus), 8'd0);

    // R9: software-cleared recovery
    autoRestart = 0; sdEnable = 1; faultMask = 4'b1000; extFault = 1; tick();
    statusClr = 1; tick(); statusClr = 0;
    chk("R9 clear refused in fault", 8'(sdStatus), 8'd1);
    extFault = 0; periodEvt = 1; tick(); periodEvt = 0;
    chk("R9 period alone ignored", 8'(sdStatus), 8'd1);
    statusClr = 1; tick(); statusClr = 0;
    chk("R9 clear accepted", 8'(sdStatus), 8'd0);
    chk("R9 levels held until period", 8'(pinOut), 8'(sdLevel));
    extFault = 1; tick(); extFault = 0;
    chk("R9 retrip while waiting", 8'(sdStatus), 8'd1);
    statusClr = 1; tick(); statusClr = 0;
    periodEvt = 1; tick(); periodEvt = 0;
    chk("R9 resume at period", 8'(pinOut), 8'(expPins()));
    chk("R9 running after period", 8'(sdStatus), 8'd0);

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      pwmIn      = 1'($urandom);
      periodEvt  = ($urandom % 6) == 0;
      statusClr  = ($urandom % 5) == 0;
      cmpFault   = (($urandom % 8) == 0) ? 3'($urandom) : '0;
      extFault   = ($urandom % 10) == 0;
      swOverride = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) begin
        steerEn = 6'($urandom); polInv = 6'($urandom); drvEn = 6'($urandom);
        sdLevel = 6'($urandom); faultMask = 4'($urandom);
        sdEnable = 1'($urandom); autoRestart = 1'($urandom);
      end
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule